// File: doc/BRIEF.md
# Tree Address Walker for Tagged Cell Memory

This unit resolves a binary tree address against a noun held in a tagged cell memory. A caller presents the memory address of a subject cell and a positive tree address, then pulses `start`. The unit walks down from the subject one level per address bit and returns the noun it reaches. That noun is either a direct atom or a pointer to a cell, and a flag tells the caller which one it is. When the walk is malformed, the unit returns an error code in place of a result.

Each memory word is 64 bits wide. It holds an 8-bit tag byte, a head field in bits 55..28 and a tail field in bits 27..0. The tree address uses the usual convention. Its leading 1 is discarded. The bits below it are then consumed from the most significant end, and each bit selects the head field (0) or the tail field (1) of the current cell. The unit reads memory through a single read port with one cycle of latency. Each read costs two cycles: an issue cycle and a data cycle. The unit allocates no cells and never writes to memory.

Top module: `slot_walk_top`

## Requirements
- R1: An address of 0 completes without any memory read: `done` rises on the cycle after `start` is sampled, with `err`=1 and `err_code`=1.
- R2: An address of 1 completes without any memory read on the cycle after `start` is sampled. It returns the subject address as `res_val` with `res_is_cell`=1.
- R3: Below the leading 1, the address bits are consumed from the most significant to the least significant. At each step, a 0 selects the head field (word bits 55..28) of the current word and a 1 selects the tail field (word bits 27..0).
- R4: When the last step selects a field whose cell tag is 0, the result is that field's value with `res_is_cell`=0. The head's cell tag is bit 57 and the tail's cell tag is bit 56.
- R5: When the last step selects a field whose cell tag is 1, the result is that field's value (a pointer) with `res_is_cell`=1, and the pointed-to word is not read.
- R6: When a step that is not the last selects a field whose cell tag is 0, the walk stops with `err_code`=2, because it cannot descend through an atom.
- R7: A word whose two cell tags are 0 and whose tail field holds all ones (NIL) is a stored lone atom. Any step taken from it ends with `err_code`=2.
- R8: A word with either traversal mark set (bit 59 for head, bit 58 for tail) ends the walk with `err_code`=3. This check takes priority over the other word checks.
- R9: A walk issues exactly one single-cycle memory read per step it takes. An address whose leading 1 is at bit n costs n reads when it succeeds.
- R10: `done` is a single-cycle pulse, and `err` is asserted only together with `done`. On an error, `res_val` is 0 and `res_is_cell` is 0.
- R11: After reset, `done`, `err` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup; sampled only while idle |
| subject | input | FIELD_W | Memory address of the subject cell |
| axis | input | AXIS_W | Tree address to resolve |
| done | output | 1 | One-cycle completion pulse |
| res_val | output | FIELD_W | Resulting atom value or cell pointer |
| res_is_cell | output | 1 | 1 when res_val is a pointer |
| err | output | 1 | Lookup failed |
| err_code | output | 2 | 1 zero address, 2 descent through atom, 3 traversal mark seen |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | FIELD_W | Memory read address |
| mem_rd_data | input | 64 | Word returned one cycle after the strobe |

## Verification
The bench builds the unit with a 28-bit field and a 16-bit address. This setting lets it place the leading 1 at the top bit and drive a fifteen-step walk down a chain of head pointers. The full 28-bit field lets it check the all-ones NIL value exactly. A small 64-word bench memory holds a shaped tree. The tree lets each error exit occur at a known step, so the read count up to the failure can be predicted.

// File: rtl/slot_pkg.sv
package slot_pkg;
  // tag byte bit offsets, relative to the top of the two fields
  localparam int TAG_TAIL_CELL = 0;
  localparam int TAG_HEAD_CELL = 1;
  localparam int TAG_TAIL_MARK = 2;
  localparam int TAG_HEAD_MARK = 3;
  localparam int TAG_W         = 8;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ZERO  = 2'd1,
    ERR_ATOM  = 2'd2,
    ERR_MARK  = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DATA  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/slot_axis_norm.sv
module slot_axis_norm #(
  parameter int AXIS_W = 32,
  localparam int SW = $clog2(AXIS_W)
) (
  input  logic [AXIS_W-1:0] axis,
  output logic              axis_zero,
  output logic [SW-1:0]     steps,
  output logic [AXIS_W-1:0] path
);
  localparam logic [SW-1:0] TOP = SW'(AXIS_W - 1);

  logic [SW-1:0] lead_pos;
  logic [SW-1:0] shamt;

  // position of the leading one = number of walk steps
  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < AXIS_W; i++) begin
      if (axis[i]) lead_pos = SW'(i);
    end
  end

  assign axis_zero = (axis == '0);
  assign steps     = lead_pos;
  assign shamt     = TOP - lead_pos;
  // first step bit lands at the MSB of path
  assign path      = (axis << shamt) << 1;
endmodule

// File: rtl/slot_cell_decode.sv
module slot_cell_decode
  import slot_pkg::*;
#(
  parameter int FIELD_W = 28,
  localparam int WORD_W = 2*FIELD_W + TAG_W
) (
  input  logic [WORD_W-1:0]  word,
  input  logic               sel_tail,
  output logic [FIELD_W-1:0] sel_val,
  output logic               sel_is_cell,
  output logic               marked,
  output logic               lone_atom
);
  localparam int TB = 2*FIELD_W;

  logic [FIELD_W-1:0] head_f, tail_f;
  logic head_cell, tail_cell;

  assign tail_f    = word[FIELD_W-1:0];
  assign head_f    = word[TB-1:FIELD_W];
  assign tail_cell = word[TB + TAG_TAIL_CELL];
  assign head_cell = word[TB + TAG_HEAD_CELL];

  assign marked    = word[TB + TAG_TAIL_MARK] | word[TB + TAG_HEAD_MARK];
  assign lone_atom = !head_cell && !tail_cell && (tail_f == '1);

  assign sel_val     = sel_tail ? tail_f    : head_f;
  assign sel_is_cell = sel_tail ? tail_cell : head_cell;
endmodule

// File: rtl/slot_walk_ctl.sv
module slot_walk_ctl
  import slot_pkg::*;
#(
  parameter int FIELD_W = 28,
  parameter int AXIS_W  = 32,
  localparam int SW = $clog2(AXIS_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FIELD_W-1:0] subject,
  input  logic               axis_zero,
  input  logic [SW-1:0]      steps,
  input  logic [AXIS_W-1:0]  path,
  input  logic [FIELD_W-1:0] sel_val,
  input  logic               sel_is_cell,
  input  logic               marked,
  input  logic               lone_atom,
  output logic               sel_tail,
  output logic               done,
  output logic [FIELD_W-1:0] res_val,
  output logic               res_is_cell,
  output logic               err,
  output logic [1:0]         err_code,
  output logic               rd_en,
  output logic [FIELD_W-1:0] rd_addr
);
  walk_st_e           st;
  logic [AXIS_W-1:0]  path_q;
  logic [SW-1:0]      left_q;
  logic               last_step;

  assign sel_tail  = path_q[AXIS_W-1];
  assign last_step = (left_q == SW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      path_q      <= '0;
      left_q      <= '0;
      done        <= 1'b0;
      res_val     <= '0;
      res_is_cell <= 1'b0;
      err         <= 1'b0;
      err_code    <= ERR_NONE;
      rd_en       <= 1'b0;
      rd_addr     <= '0;
    end else begin
      done  <= 1'b0;
      rd_en <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (axis_zero) begin
              done        <= 1'b1;
              err         <= 1'b1;
              err_code    <= ERR_ZERO;
              res_val     <= '0;
              res_is_cell <= 1'b0;
            end else if (steps == '0) begin
              done        <= 1'b1;
              err         <= 1'b0;
              err_code    <= ERR_NONE;
              res_val     <= subject;
              res_is_cell <= 1'b1;
            end else begin
              err     <= 1'b0;
              path_q  <= path;
              left_q  <= steps;
              rd_addr <= subject;
              rd_en   <= 1'b1;
              st      <= ST_ISSUE;
            end
          end else begin
            err <= 1'b0;
          end
        end
        ST_ISSUE: st <= ST_DATA;
        ST_DATA: begin
          if (marked || lone_atom || (!sel_is_cell && !last_step)) begin
            done        <= 1'b1;
            err         <= 1'b1;
            err_code    <= marked ? ERR_MARK : ERR_ATOM;
            res_val     <= '0;
            res_is_cell <= 1'b0;
            st          <= ST_IDLE;
          end else if (last_step) begin
            done        <= 1'b1;
            err_code    <= ERR_NONE;
            res_val     <= sel_val;
            res_is_cell <= sel_is_cell;
            st          <= ST_IDLE;
          end else begin
            rd_addr <= sel_val;
            rd_en   <= 1'b1;
            path_q  <= path_q << 1;
            left_q  <= left_q - SW'(1);
            st      <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: completion is a one-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: error only reported alongside completion
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R9: each read strobe lasts one cycle
  p_rd_single_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);
  // R1: zero address ends next cycle with code 1 and no read
  p_zero_axis_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start && axis_zero) |=> (done && err && err_code == 2'd1 && !rd_en));
  // R2: address 1 returns the subject pointer next cycle
  p_axis_one_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start && !axis_zero && steps == '0)
      |=> (done && !err && res_is_cell && res_val == $past(subject)));
  // R8: a marked word always ends the walk with code 3
  p_mark_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && marked) |=> (done && err_code == 2'd3));
endmodule

// File: rtl/slot_walk_top.sv
module slot_walk_top
  import slot_pkg::*;
#(
  parameter int FIELD_W = 28,
  parameter int AXIS_W  = 32,
  localparam int WORD_W = 2*FIELD_W + TAG_W,
  localparam int SW     = $clog2(AXIS_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FIELD_W-1:0] subject,
  input  logic [AXIS_W-1:0]  axis,
  output logic               done,
  output logic [FIELD_W-1:0] res_val,
  output logic               res_is_cell,
  output logic               err,
  output logic [1:0]         err_code,
  output logic               mem_rd_en,
  output logic [FIELD_W-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0]  mem_rd_data
);
  logic               axis_zero;
  logic [SW-1:0]      steps;
  logic [AXIS_W-1:0]  path;
  logic               sel_tail;
  logic [FIELD_W-1:0] sel_val;
  logic               sel_is_cell, marked, lone_atom;

  slot_axis_norm #(.AXIS_W(AXIS_W)) u_norm (
    .axis(axis), .axis_zero(axis_zero), .steps(steps), .path(path)
  );

  slot_cell_decode #(.FIELD_W(FIELD_W)) u_dec (
    .word(mem_rd_data), .sel_tail(sel_tail), .sel_val(sel_val),
    .sel_is_cell(sel_is_cell), .marked(marked), .lone_atom(lone_atom)
  );

  slot_walk_ctl #(.FIELD_W(FIELD_W), .AXIS_W(AXIS_W)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .subject(subject),
    .axis_zero(axis_zero), .steps(steps), .path(path),
    .sel_val(sel_val), .sel_is_cell(sel_is_cell), .marked(marked),
    .lone_atom(lone_atom), .sel_tail(sel_tail), .done(done),
    .res_val(res_val), .res_is_cell(res_is_cell), .err(err),
    .err_code(err_code), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr)
  );
endmodule

// File: tb/slot_walk_top_bench.sv
module slot_walk_top_bench;
  localparam int FW = 28;
  localparam int AW = 16;
  localparam int CLK_PERIOD = 10;
  localparam logic [FW-1:0] NIL = '1;
  localparam int NV = 15;
  // {subject 28, axis 16, err_code 2, value 28, is_cell 1, reads 5}
  localparam logic [79:0] VECS [NV] = '{
    {28'd1, 16'd1,  2'd0, 28'd1,  1'b1, 5'd0},  // R2
    {28'd1, 16'd0,  2'd1, 28'd0,  1'b0, 5'd0},  // R1
    {28'd1, 16'd2,  2'd0, 28'd2,  1'b1, 5'd1},  // R5 head ptr
    {28'd1, 16'd3,  2'd0, 28'd3,  1'b1, 5'd1},  // R5 tail ptr
    {28'd1, 16'd4,  2'd0, 28'd42, 1'b0, 5'd2},  // R3 R4
    {28'd1, 16'd5,  2'd0, 28'd43, 1'b0, 5'd2},  // R3 R4
    {28'd1, 16'd7,  2'd0, 28'd7,  1'b0, 5'd2},  // R4
    {28'd1, 16'd6,  2'd0, 28'd4,  1'b1, 5'd2},  // R3 R5
    {28'd1, 16'd12, 2'd2, 28'd0,  1'b0, 5'd3},  // R7 lone atom
    {28'd1, 16'd13, 2'd2, 28'd0,  1'b0, 5'd3},  // R7
    {28'd1, 16'd8,  2'd2, 28'd0,  1'b0, 5'd2},  // R6
    {28'd1, 16'd14, 2'd2, 28'd0,  1'b0, 5'd2},  // R6
    {28'd6, 16'd2,  2'd0, 28'd5,  1'b1, 5'd1},  // R5 no read of target
    {28'd6, 16'd4,  2'd3, 28'd0,  1'b0, 5'd2},  // R8
    {28'd7, 16'd3,  2'd3, 28'd0,  1'b0, 5'd1}   // R8 priority over lone
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [FW-1:0] subject = '0;
  logic [AW-1:0] axis = '0;
  logic done, res_is_cell, err, mem_rd_en;
  logic [FW-1:0] res_val, mem_rd_addr;
  logic [1:0] err_code;
  logic [63:0] mem_rd_data;
  logic [63:0] mem [64];
  int total = 0, bad = 0, reads = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_walk_top #(.FIELD_W(FW), .AXIS_W(AW)) u_slot_walk_top (
    .clk(clk), .rst(rst), .start(start), .subject(subject), .axis(axis),
    .done(done), .res_val(res_val), .res_is_cell(res_is_cell), .err(err),
    .err_code(err_code), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data)
  );

  always_ff @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_addr[5:0]];
      reads <= reads + 1;
    end
  end

  function automatic logic [63:0] mk(input logic [7:0] tg, input logic [FW-1:0] h,
                                     input logic [FW-1:0] t);
    return {tg, h, t};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [FW-1:0] s, input logic [AW-1:0] a, input string req,
                     input logic [1:0] ec, input logic [FW-1:0] v, input logic c,
                     input int nr);
    int wd = 0;
    @(negedge clk);
    reads = 0;
    subject = s; axis = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && wd < 200) begin
      @(negedge clk);
      wd++;
    end
    chk({req, " done seen"}, 64'(done), 64'd1);
    chk({req, " err"}, 64'(err), 64'(ec != 2'd0));
    chk({req, " code"}, 64'(err_code), 64'(ec));
    chk({req, " value"}, 64'(res_val), 64'(v));
    chk({req, " is_cell"}, 64'(res_is_cell), 64'(c));
    chk({req, " R9 reads"}, 64'(reads), 64'(nr));
    @(negedge clk);
    chk({req, " R10 pulse"}, 64'(done), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[1] = mk(8'h03, 28'd2, 28'd3);     // [ptr2 ptr3]
    mem[2] = mk(8'h00, 28'd42, 28'd43);   // [42 43]
    mem[3] = mk(8'h02, 28'd4, 28'd7);     // [ptr4 7]
    mem[4] = mk(8'h00, 28'd99, NIL);      // lone atom 99
    mem[5] = mk(8'h0A, 28'd2, 28'd5);     // head mark set
    mem[6] = mk(8'h02, 28'd5, 28'd0);     // [ptr5 0]
    mem[7] = mk(8'h04, 28'd11, NIL);      // lone atom with tail mark
    for (int i = 0; i < 15; i++)          // head chain 20..34
      mem[20+i] = (i == 14) ? mk(8'h00, 28'h777, 28'd1)
                            : mk(8'h02, 28'(21+i), 28'(i));
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 done", 64'(done), 64'd0);
    chk("R11 err", 64'(err), 64'd0);
    chk("R11 rd_en", 64'(mem_rd_en), 64'd0);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      run(VECS[k][79:52], VECS[k][51:36], $sformatf("vec%0d", k), VECS[k][35:34],
          VECS[k][33:6], VECS[k][5], int'(VECS[k][4:0]));
    end
    // R3 R9: leading one at top bit, fifteen head steps
    run(28'd20, 16'h8000, "R3 deep chain", 2'd0, 28'h777, 1'b0, 15);
    // R1 latency: done visible right after start sampled
    @(negedge clk);
    axis = '0; subject = 28'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 next-cycle done", 64'(done), 64'd1);
    // R2 latency
    @(negedge clk);
    axis = 16'd1; subject = 28'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 next-cycle done", 64'(done), 64'd1);
    chk("R2 subject value", 64'(res_val), 64'd9);
    // R11 reset mid-walk
    @(negedge clk);
    axis = 16'h8000; subject = 28'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 rd_en after reset", 64'(mem_rd_en), 64'd0);
    chk("R11 done after reset", 64'(done), 64'd0);
    rst = 1'b0;
    run(28'd1, 16'd5, "R3 after reset", 2'd0, 28'd43, 1'b0, 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule